// File: doc/BRIEF.md
# Overlap-Safe Memory Protection Unit

This block sits beside a bus and decides, for every access, whether it may proceed. It keeps a small set of programmable address windows. Each window holds an inclusive lower and upper address, a read permission, a write permission, an enable bit and the privilege level of whoever last programmed it. An access request presents an address and a read/write flag; one clock later the block answers with a registered grant or deny. Every deny also raises a single-cycle violation pulse and latches the offending address and access type.

Windows may cover common addresses, so the block resolves this in a defined way. A runtime policy bit selects between two schemes: the lowest-numbered matching window alone decides, or every matching window must permit the access. Only the most privileged requester may change that policy. Configuration writes carry a privilege tag. A writer can never replace a window owned by a more privileged writer, and can never place an enabled window on top of one. A build option extends that refusal to any overlap at all. A refused write leaves every window unchanged and sets a sticky error flag.

Top module: `mpu_guard`

## Requirements
- R1: An access matches window i when window i is enabled and its lower bound <= address <= its upper bound (both bounds inclusive). A disabled window never matches. There are N_REG windows, three by default, numbered from 0.
- R2: An access that matches no window is denied.
- R3: Each cycle with `acc_req` high gives exactly one response. `rsp_valid` is high in the following cycle and low in every other cycle.
- R4: With policy 0 (ordered), only the matching window with the smallest number decides. A read needs its read bit and a write (`acc_write`=1) needs its write bit.
- R5: With policy 1 (combined), an access is granted only if at least one window matches and every matching window allows that access type.
- R6: A policy write (`cfg_op`=1, new value on `cfg_mode`) takes effect only when `cfg_priv` is the highest level (all ones). From any other level the write is refused and the policy keeps its value. The policy is 0 after reset.
- R7: A window write (`cfg_op`=0, target `cfg_idx`) is accepted only if `cfg_priv` is greater than or equal to the privilege recorded for that window. An accepted write records `cfg_priv` as the new owner. After reset every owner is 0.
- R8: An enabling window write is refused if its range shares any address with a different enabled window whose owner is more privileged than `cfg_priv`.
- R9: When OVERLAP_CHECK is 1, an enabling window write is refused if its range shares any address with any different enabled window, whatever the owners. Rewriting the same window is not counted as overlap.
- R10: A refused configuration write leaves all windows and the policy unchanged, and sets `cfg_err`. `cfg_err` then stays high until reset.
- R11: A denied access makes `viol_pulse` high for exactly the response cycle. `viol_addr` and `viol_write` then hold the address and access type of that request until the next deny.
- R12: An enabling window write whose lower bound exceeds its upper bound is refused, and so is a write to an index of N_REG or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | 1 | 0 = window write, 1 = policy write |
| cfg_idx | input | IDX_W | Window number for a window write |
| cfg_priv | input | PRIV_W | Privilege of the writer, larger is more privileged |
| cfg_base | input | ADDR_W | Inclusive lower bound |
| cfg_limit | input | ADDR_W | Inclusive upper bound |
| cfg_rd | input | 1 | Read permission |
| cfg_wr | input | 1 | Write permission |
| cfg_en | input | 1 | Window enable |
| cfg_mode | input | 1 | New policy: 0 ordered, 1 combined |
| acc_req | input | 1 | Access check request |
| acc_addr | input | ADDR_W | Address to check |
| acc_write | input | 1 | 1 = write access, 0 = read |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_grant | output | 1 | Access allowed |
| viol_pulse | output | 1 | One-cycle pulse on a deny |
| viol_addr | output | ADDR_W | Address of the last denied access |
| viol_write | output | 1 | Access type of the last denied access |
| cfg_err | output | 1 | Sticky refused-configuration flag |

## Verification
The bench builds two copies with 16-bit addresses, two privilege bits and three windows. One copy has OVERLAP_CHECK at 0. Windows can then really share addresses, so both policies can be shown giving different answers for the same access, and the owner-based refusals are the only guard. The other copy has OVERLAP_CHECK at 1. There, two equally privileged writers are refused on a single shared address, while adjacent windows and the rewriting of a window over its own old range are still accepted.

// File: rtl/mpu_guard_pkg.sv
package mpu_guard_pkg;

   localparam logic CFG_OP_REGION = 1'b0;
   localparam logic CFG_OP_MODE   = 1'b1;

   localparam logic POL_ORDERED   = 1'b0;
   localparam logic POL_COMBINED  = 1'b1;

   function automatic int unsigned idx_width(int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/mpu_region_file.sv
module mpu_region_file
   import mpu_guard_pkg::*;
#(
   parameter int unsigned N_REG         = 3,
   parameter int unsigned ADDR_W        = 32,
   parameter int unsigned PRIV_W        = 2,
   parameter int unsigned OVERLAP_CHECK = 0,
   parameter logic        RESET_MODE    = POL_ORDERED,
   localparam int unsigned IDX_W        = idx_width(N_REG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_op,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [PRIV_W-1:0] cfg_priv,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [ADDR_W-1:0] cfg_limit,
   input  logic              cfg_rd,
   input  logic              cfg_wr,
   input  logic              cfg_en,
   input  logic              cfg_mode,
   output logic [ADDR_W-1:0] base_q  [N_REG],
   output logic [ADDR_W-1:0] limit_q [N_REG],
   output logic [N_REG-1:0]  rd_q,
   output logic [N_REG-1:0]  wr_q,
   output logic [N_REG-1:0]  en_q,
   output logic              mode_q,
   output logic              cfg_err
);

   localparam logic [PRIV_W-1:0] TOP_PRIV = {PRIV_W{1'b1}};
   localparam logic [IDX_W-1:0]  MAX_IDX  = IDX_W'(N_REG - 1);

   logic [PRIV_W-1:0] own_q [N_REG];
   logic [PRIV_W-1:0] own_sel;
   logic [N_REG-1:0]  ovl;
   logic              ovl_block;
   logic              idx_ok;
   logic              range_ok;
   logic              region_ok;
   logic              mode_ok;
   logic              wr_region;
   logic              wr_mode;
   logic              refuse;

   // owner of the addressed window
   always_comb begin
      own_sel = '0;
      for (int i = 0; i < int'(N_REG); i++) begin
         if (cfg_idx == IDX_W'(i)) own_sel = own_q[i];
      end
   end

   // shared-address detection against every other enabled window
   for (genvar j = 0; j < int'(N_REG); j++) begin : g_ovl
      assign ovl[j] = en_q[j] && (cfg_idx != IDX_W'(j)) &&
                      (cfg_base <= limit_q[j]) && (base_q[j] <= cfg_limit);
   end

   if (OVERLAP_CHECK != 0) begin : g_strict
      assign ovl_block = |ovl;
   end else begin : g_owner
      logic [N_REG-1:0] ovl_hi;
      for (genvar j = 0; j < int'(N_REG); j++) begin : g_hi
         assign ovl_hi[j] = ovl[j] && (own_q[j] > cfg_priv);
      end
      assign ovl_block = |ovl_hi;
   end

   assign idx_ok    = (cfg_idx <= MAX_IDX);
   assign range_ok  = !cfg_en || (cfg_base <= cfg_limit);
   assign region_ok = idx_ok && range_ok && (cfg_priv >= own_sel) &&
                      !(cfg_en && ovl_block);
   assign mode_ok   = (cfg_priv == TOP_PRIV);

   assign wr_region = cfg_we && (cfg_op == CFG_OP_REGION) && region_ok;
   assign wr_mode   = cfg_we && (cfg_op == CFG_OP_MODE) && mode_ok;
   assign refuse    = cfg_we && !wr_region && !wr_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(N_REG); i++) begin
            base_q[i]  <= '0;
            limit_q[i] <= '0;
            own_q[i]   <= '0;
         end
         rd_q <= '0;
         wr_q <= '0;
         en_q <= '0;
      end else if (wr_region) begin
         for (int i = 0; i < int'(N_REG); i++) begin
            if (cfg_idx == IDX_W'(i)) begin
               base_q[i]  <= cfg_base;
               limit_q[i] <= cfg_limit;
               own_q[i]   <= cfg_priv;
               rd_q[i]    <= cfg_rd;
               wr_q[i]    <= cfg_wr;
               en_q[i]    <= cfg_en;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= RESET_MODE;
         cfg_err <= 1'b0;
      end else begin
         if (wr_mode) mode_q <= cfg_mode;
         if (refuse)  cfg_err <= 1'b1;
      end
   end

endmodule

// File: rtl/mpu_match.sv
module mpu_match #(
   parameter int unsigned N_REG  = 3,
   parameter int unsigned ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] base_q  [N_REG],
   input  logic [ADDR_W-1:0] limit_q [N_REG],
   input  logic [N_REG-1:0]  rd_q,
   input  logic [N_REG-1:0]  wr_q,
   input  logic [N_REG-1:0]  en_q,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_write,
   output logic [N_REG-1:0]  hit,
   output logic [N_REG-1:0]  allow
);

   for (genvar i = 0; i < int'(N_REG); i++) begin : g_win
      assign hit[i]   = en_q[i] && (acc_addr >= base_q[i]) && (acc_addr <= limit_q[i]);
      assign allow[i] = acc_write ? wr_q[i] : rd_q[i];
   end

endmodule

// File: rtl/mpu_resolve.sv
module mpu_resolve
   import mpu_guard_pkg::*;
#(
   parameter int unsigned N_REG = 3
) (
   input  logic [N_REG-1:0] hit,
   input  logic [N_REG-1:0] allow,
   input  logic             mode,
   output logic             grant
);

   logic ordered_ok;
   logic seen;
   logic combined_ok;

   // lowest-numbered hit decides
   always_comb begin
      ordered_ok = 1'b0;
      seen       = 1'b0;
      for (int i = 0; i < int'(N_REG); i++) begin
         if (!seen && hit[i]) begin
            ordered_ok = allow[i];
            seen       = 1'b1;
         end
      end
   end

   // every hit must agree
   assign combined_ok = (|hit) && (&(allow | ~hit));

   assign grant = (mode == POL_COMBINED) ? combined_ok : ordered_ok;

endmodule

// File: rtl/mpu_guard.sv
module mpu_guard
   import mpu_guard_pkg::*;
#(
   parameter int unsigned N_REG         = 3,
   parameter int unsigned ADDR_W        = 32,
   parameter int unsigned PRIV_W        = 2,
   parameter int unsigned OVERLAP_CHECK = 0,
   parameter logic        RESET_MODE    = POL_ORDERED,
   localparam int unsigned IDX_W        = idx_width(N_REG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_op,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [PRIV_W-1:0] cfg_priv,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [ADDR_W-1:0] cfg_limit,
   input  logic              cfg_rd,
   input  logic              cfg_wr,
   input  logic              cfg_en,
   input  logic              cfg_mode,
   input  logic              acc_req,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_write,
   output logic              rsp_valid,
   output logic              rsp_grant,
   output logic              viol_pulse,
   output logic [ADDR_W-1:0] viol_addr,
   output logic              viol_write,
   output logic              cfg_err
);

   if (N_REG < 1 || N_REG > 64) begin : g_bad_nreg
      $error("mpu_guard: N_REG must be 1..64");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("mpu_guard: ADDR_W must be positive");
   end
   if (PRIV_W < 1 || PRIV_W > 8) begin : g_bad_priv
      $error("mpu_guard: PRIV_W must be 1..8");
   end
   if (OVERLAP_CHECK > 1) begin : g_bad_ovl
      $error("mpu_guard: OVERLAP_CHECK must be 0 or 1");
   end

   logic [ADDR_W-1:0] base_q  [N_REG];
   logic [ADDR_W-1:0] limit_q [N_REG];
   logic [N_REG-1:0]  rd_q;
   logic [N_REG-1:0]  wr_q;
   logic [N_REG-1:0]  en_q;
   logic              mode_q;
   logic [N_REG-1:0]  hit_v;
   logic [N_REG-1:0]  allow_v;
   logic              grant_c;

   mpu_region_file #(
      .N_REG        (N_REG),
      .ADDR_W       (ADDR_W),
      .PRIV_W       (PRIV_W),
      .OVERLAP_CHECK(OVERLAP_CHECK),
      .RESET_MODE   (RESET_MODE)
   ) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_op   (cfg_op),
      .cfg_idx  (cfg_idx),
      .cfg_priv (cfg_priv),
      .cfg_base (cfg_base),
      .cfg_limit(cfg_limit),
      .cfg_rd   (cfg_rd),
      .cfg_wr   (cfg_wr),
      .cfg_en   (cfg_en),
      .cfg_mode (cfg_mode),
      .base_q   (base_q),
      .limit_q  (limit_q),
      .rd_q     (rd_q),
      .wr_q     (wr_q),
      .en_q     (en_q),
      .mode_q   (mode_q),
      .cfg_err  (cfg_err)
   );

   mpu_match #(
      .N_REG (N_REG),
      .ADDR_W(ADDR_W)
   ) match_i (
      .base_q   (base_q),
      .limit_q  (limit_q),
      .rd_q     (rd_q),
      .wr_q     (wr_q),
      .en_q     (en_q),
      .acc_addr (acc_addr),
      .acc_write(acc_write),
      .hit      (hit_v),
      .allow    (allow_v)
   );

   mpu_resolve #(
      .N_REG(N_REG)
   ) resolve_i (
      .hit  (hit_v),
      .allow(allow_v),
      .mode (mode_q),
      .grant(grant_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_grant  <= 1'b0;
         viol_pulse <= 1'b0;
         viol_addr  <= '0;
         viol_write <= 1'b0;
      end else begin
         rsp_valid  <= acc_req;
         rsp_grant  <= acc_req && grant_c;
         viol_pulse <= acc_req && !grant_c;
         if (acc_req && !grant_c) begin
            viol_addr  <= acc_addr;
            viol_write <= acc_write;
         end
      end
   end

endmodule

// File: rtl/mpu_guard_chk.sv
module mpu_guard_chk
   import mpu_guard_pkg::*;
#(
   parameter int unsigned N_REG  = 3,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned PRIV_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic              cfg_op,
   input logic [PRIV_W-1:0] cfg_priv,
   input logic              acc_req,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              acc_write,
   input logic              rsp_valid,
   input logic              rsp_grant,
   input logic              viol_pulse,
   input logic [ADDR_W-1:0] viol_addr,
   input logic              viol_write,
   input logic              cfg_err,
   input logic              mode_q,
   input logic [N_REG-1:0]  hit_v
);

   localparam logic [PRIV_W-1:0] TOP_PRIV = {PRIV_W{1'b1}};

   AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      acc_req |=> rsp_valid); // R3

   AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_req |=> !rsp_valid); // R3

   AST_NO_HIT_DENY: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req && (hit_v == '0)) |=> !rsp_grant); // R2

   AST_VIOL_ON_DENY: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_grant) |-> viol_pulse); // R11

   AST_VIOL_ONLY_DENY: assert property (@(posedge clk) disable iff (!rst_n)
      viol_pulse |-> (rsp_valid && !rsp_grant)); // R11

   AST_VIOL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      viol_pulse |-> ((viol_addr == $past(acc_addr)) && (viol_write == $past(acc_write)))); // R11

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> cfg_err); // R10

   AST_MODE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && (cfg_op == CFG_OP_MODE) && (cfg_priv != TOP_PRIV)) |=> $stable(mode_q)); // R6

endmodule

bind mpu_guard mpu_guard_chk #(
   .N_REG (N_REG),
   .ADDR_W(ADDR_W),
   .PRIV_W(PRIV_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_op    (cfg_op),
   .cfg_priv  (cfg_priv),
   .acc_req   (acc_req),
   .acc_addr  (acc_addr),
   .acc_write (acc_write),
   .rsp_valid (rsp_valid),
   .rsp_grant (rsp_grant),
   .viol_pulse(viol_pulse),
   .viol_addr (viol_addr),
   .viol_write(viol_write),
   .cfg_err   (cfg_err),
   .mode_q    (mode_q),
   .hit_v     (hit_v)
);

// File: tb/mpu_guard_tb_top.sv
`timescale 1ns/1ps
module mpu_guard_tb_top;

   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we_a = 1'b0, cfg_we_b = 1'b0;
   logic          cfg_op = 1'b0;
   logic [1:0]    cfg_idx = '0;
   logic [1:0]    cfg_priv = '0;
   logic [AW-1:0] cfg_base = '0, cfg_limit = '0;
   logic          cfg_rd = 1'b0, cfg_wr = 1'b0, cfg_en = 1'b0, cfg_mode = 1'b0;
   logic          acc_req_a = 1'b0, acc_req_b = 1'b0;
   logic [AW-1:0] acc_addr = '0;
   logic          acc_write = 1'b0;

   logic          rv_a, gr_a, vp_a, vw_a, err_a;
   logic          rv_b, gr_b, vp_b, vw_b, err_b;
   logic [AW-1:0] va_a, va_b;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   typedef struct {
      bit        tgt;
      logic [AW-1:0] addr;
      bit        wr;
      bit        grant;
      string     req;
   } exp_t;
   exp_t sb_q[$];

   always #4 clk = ~clk;

   mpu_guard #(.N_REG(3), .ADDR_W(AW), .PRIV_W(2), .OVERLAP_CHECK(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we_a), .cfg_op(cfg_op), .cfg_idx(cfg_idx),
      .cfg_priv(cfg_priv), .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_rd(cfg_rd),
      .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_mode(cfg_mode), .acc_req(acc_req_a),
      .acc_addr(acc_addr), .acc_write(acc_write), .rsp_valid(rv_a), .rsp_grant(gr_a),
      .viol_pulse(vp_a), .viol_addr(va_a), .viol_write(vw_a), .cfg_err(err_a));

   mpu_guard #(.N_REG(3), .ADDR_W(AW), .PRIV_W(2), .OVERLAP_CHECK(1)) dut_chk_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we_b), .cfg_op(cfg_op), .cfg_idx(cfg_idx),
      .cfg_priv(cfg_priv), .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_rd(cfg_rd),
      .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_mode(cfg_mode), .acc_req(acc_req_b),
      .acc_addr(acc_addr), .acc_write(acc_write), .rsp_valid(rv_b), .rsp_grant(gr_b),
      .viol_pulse(vp_b), .viol_addr(va_b), .viol_write(vw_b), .cfg_err(err_b));

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // driver: one access, expected result queued for the monitor
   task automatic access(bit tgt, logic [AW-1:0] addr, bit wr, bit exp, string req);
      exp_t e;
      e.tgt = tgt; e.addr = addr; e.wr = wr; e.grant = exp; e.req = req;
      sb_q.push_back(e);
      acc_addr  = addr;
      acc_write = wr;
      if (tgt) acc_req_b = 1'b1; else acc_req_a = 1'b1;
      @(negedge clk);
      acc_req_a = 1'b0;
      acc_req_b = 1'b0;
   endtask

   task automatic set_region(bit tgt, logic [1:0] priv, logic [1:0] idx, logic [AW-1:0] lo,
                             logic [AW-1:0] hi, bit rd, bit wr, bit en);
      cfg_op = 1'b0; cfg_priv = priv; cfg_idx = idx; cfg_base = lo; cfg_limit = hi;
      cfg_rd = rd; cfg_wr = wr; cfg_en = en;
      if (tgt) cfg_we_b = 1'b1; else cfg_we_a = 1'b1;
      @(negedge clk);
      cfg_we_a = 1'b0;
      cfg_we_b = 1'b0;
   endtask

   task automatic set_mode(logic [1:0] priv, bit mode);
      cfg_op = 1'b1; cfg_priv = priv; cfg_mode = mode; cfg_we_a = 1'b1;
      @(negedge clk);
      cfg_we_a = 1'b0;
   endtask

   // monitor: pops the scoreboard as responses appear
   always @(negedge clk) begin
      if (rst_n && (rv_a || rv_b)) begin
         if (sb_q.size() == 0) begin
            check("R3", "unexpected response", 1, 0);
         end else begin
            exp_t e;
            bit g, v, w;
            logic [AW-1:0] a;
            e = sb_q.pop_front();
            g = e.tgt ? gr_b : gr_a;
            v = e.tgt ? vp_b : vp_a;
            a = e.tgt ? va_b : va_a;
            w = e.tgt ? vw_b : vw_a;
            check("R3", "response on addressed unit", e.tgt ? rv_b : rv_a, 1);
            check(e.req, $sformatf("grant @%0h wr=%0d", e.addr, e.wr), g, e.grant);
            check("R11", "violation pulse", v, !e.grant);
            if (!e.grant) begin
               check("R11", "captured address", a, e.addr);
               check("R11", "captured type", w, e.wr);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R3", "reset rsp_valid", rv_a, 0);
      check("R11", "reset viol_pulse", vp_a, 0);
      check("R10", "reset cfg_err", err_a, 0);
      check("R10", "reset cfg_err b", err_b, 0);
      access(0, 16'h1000, 0, 0, "R2");           // nothing programmed

      // window 0 read-only, window 1 write-only, overlapping on 1800..1FFF
      set_region(0, 2'd3, 2'd0, 16'h1000, 16'h1FFF, 1, 0, 1);
      set_region(0, 2'd3, 2'd1, 16'h1800, 16'h27FF, 0, 1, 1);
      set_region(0, 2'd1, 2'd2, 16'h3000, 16'h3000, 0, 1, 1);
      check("R10", "no error after valid writes", err_a, 0);

      // ordered policy
      access(0, 16'h0FFF, 0, 0, "R1");
      access(0, 16'h1000, 0, 1, "R1");
      access(0, 16'h1900, 0, 1, "R4");
      access(0, 16'h1900, 1, 0, "R4");
      access(0, 16'h2000, 1, 1, "R4");
      access(0, 16'h2000, 0, 0, "R4");
      access(0, 16'h27FF, 1, 1, "R1");
      access(0, 16'h2800, 1, 0, "R2");
      access(0, 16'h3000, 1, 1, "R1");
      access(0, 16'h3000, 0, 0, "R1");
      access(0, 16'h0100, 0, 0, "R2");

      // untrusted policy change refused
      set_mode(2'd1, 1'b1);
      check("R6", "cfg_err after untrusted policy write", err_a, 1);
      access(0, 16'h1900, 0, 1, "R6");

      // trusted change to combined policy
      set_mode(2'd3, 1'b1);
      access(0, 16'h1900, 0, 0, "R5");
      access(0, 16'h1900, 1, 0, "R5");
      access(0, 16'h2000, 1, 1, "R5");
      access(0, 16'h1000, 0, 1, "R5");

      // owner protection
      set_region(0, 2'd0, 2'd2, 16'h3000, 16'h3000, 1, 0, 1);
      access(0, 16'h3000, 1, 1, "R7");
      access(0, 16'h3000, 0, 0, "R7");
      set_region(0, 2'd1, 2'd2, 16'h3000, 16'h3000, 1, 0, 1);
      access(0, 16'h3000, 0, 1, "R7");

      // overlap onto a more privileged window refused
      set_region(0, 2'd2, 2'd2, 16'h1F00, 16'h1F10, 1, 1, 1);
      access(0, 16'h3000, 0, 1, "R8");
      set_region(0, 2'd2, 2'd2, 16'h4000, 16'h40FF, 1, 0, 1);
      access(0, 16'h40FF, 0, 1, "R8");
      access(0, 16'h3000, 0, 0, "R8");

      // inverted range refused
      set_region(0, 2'd3, 2'd2, 16'h5000, 16'h4000, 1, 1, 1);
      access(0, 16'h4000, 0, 1, "R12");
      access(0, 16'h5000, 0, 0, "R12");
      check("R10", "cfg_err stays set", err_a, 1);

      // disabling a window removes its match
      set_region(0, 2'd3, 2'd0, 16'h1000, 16'h1FFF, 1, 0, 0);
      access(0, 16'h1000, 0, 0, "R1");

      // strict overlap build
      set_region(1, 2'd3, 2'd0, 16'h1000, 16'h1FFF, 1, 1, 1);
      check("R9", "cfg_err b after clean write", err_b, 0);
      set_region(1, 2'd3, 2'd1, 16'h1FFF, 16'h2FFF, 1, 1, 1);
      check("R9", "cfg_err b after one-address overlap", err_b, 1);
      access(1, 16'h2500, 0, 0, "R9");
      set_region(1, 2'd3, 2'd1, 16'h2000, 16'h2FFF, 1, 1, 1);
      access(1, 16'h2500, 0, 1, "R9");
      access(1, 16'h1FFF, 1, 1, "R9");
      set_region(1, 2'd3, 2'd0, 16'h1000, 16'h1800, 1, 1, 1);
      access(1, 16'h1900, 0, 0, "R9");
      access(1, 16'h1800, 1, 1, "R9");

      repeat (3) @(negedge clk);
      check("R3", "scoreboard drained", sb_q.size(), 0);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule